// File: doc/BRIEF.md
# Bit-Serial Approximate Min-Sum Check Node

This block is the check-side update unit of an iterative min-sum decoder for sparse parity-check codes. It has `DEG` edges. Each edge brings in one message on a single wire, one bit per clock, and sends one message back the same way. A message is `MSG_W` bits long in sign-magnitude form. The sign comes first, then the magnitude from its most significant bit down. A start strobe marks the clock that carries the sign bit.

While the magnitude bits stream in, the node works out the smallest input magnitude one bit per clock. It keeps a candidate flag for each edge, and an edge stays a candidate only while its bits match the running minimum. It does not store a first and a second minimum. Instead it applies an approximate rule. When exactly one edge holds the minimum, that edge is sent the minimum plus one and every other edge is sent the minimum. When the minimum is tied, every edge is sent the minimum. The output sign for an edge is the XOR of every other edge's sign. The XOR of all signs is also presented as a parity flag, which an early-termination controller can combine across nodes.

The result is only known once the last magnitude bit has arrived. For that reason each outgoing word is loaded into a register and shifted out during the next `MSG_W` enabled clocks, which lets frames run back to back. When the enable input is low, the whole node holds still.

Top module: `minsum_chk_node`

## Requirements
- R1: While reset is high and after its release, `dout` and `par_out` read all zeros until the first completed frame has been loaded.
- R2: An enabled clock with `sof` high takes the sign bit. The next `MSG_W-1` enabled clocks take the magnitude, most significant bit first. The outgoing word appears on `dout` over the next `MSG_W` enabled clocks, starting the clock after the last magnitude bit is taken, in the same order: sign first, then magnitude MSB first.
- R3: The outgoing sign on edge i is the XOR of the incoming signs of all edges except i.
- R4: `par_out` equals the XOR of all incoming signs of the frame that was last loaded. It changes only on the clock that loads a frame.
- R5: If two or more edges share the smallest magnitude, every edge's outgoing magnitude equals that minimum.
- R6: If exactly one edge holds the smallest magnitude, that edge's outgoing magnitude is the minimum plus one and every other edge's outgoing magnitude is the minimum.
- R7: While `en` is low, no input bit or `sof` is taken, and `dout`, `par_out` and all internal progress hold their values.
- R8: After a word has been shifted out and no new frame has completed, `dout` reads zero on every edge.
- R9: A `sof` that arrives before a frame is complete abandons that frame and starts capturing a new one. The abandoned frame produces no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enable; low freezes the node |
| sof | input | 1 | Marks the clock that carries the sign bits |
| din | input | DEG | One serial message bit per edge |
| dout | output | DEG | One serial outgoing bit per edge |
| par_out | output | 1 | XOR of all signs of the last loaded frame |

## Verification
A candidate flag that drops out wrongly, or one that survives when it should not, shows up at the ports as a single edge whose magnitude is off by one. The unique-versus-tie decision flips. This is visible within the slot that follows the frame. If the sign register or the bit counter is corrupted, every edge's sign or every edge's bit alignment goes wrong in that same output slot. A frozen-state violation during a low enable shows up as `dout` moving between two held samples. The sweep covers every combination of magnitudes on four edges. It therefore reaches every unique-minimum position and every tie pattern at every minimum value.

// File: rtl/ckn_pkg.sv
package ckn_pkg;
  function automatic logic is_single(input logic [31:0] v);
    return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
  endfunction
endpackage

// File: rtl/ckn_min_track.sv
module ckn_min_track #(
  parameter int DEG   = 4,
  parameter int MAG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             step,
  input  logic [DEG-1:0]   bits,
  output logic [DEG-1:0]   cand_nx,
  output logic [MAG_W-1:0] min_now
);
  logic [DEG-1:0]   cand_q;
  logic [MAG_W-1:0] min_q;
  logic             min_bit;

  // a surviving candidate showing 0 pulls the minimum bit down
  assign min_bit = ~|(cand_q & ~bits);
  assign cand_nx = min_bit ? cand_q : (cand_q & ~bits);
  assign min_now = {min_q[MAG_W-2:0], min_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q <= '0;
      min_q  <= '0;
    end else if (start) begin
      cand_q <= '1;
      min_q  <= '0;
    end else if (step) begin
      cand_q <= cand_nx;
      min_q  <= min_now;
    end
  end
endmodule

// File: rtl/ckn_sign_par.sv
module ckn_sign_par #(
  parameter int DEG = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cap,
  input  logic [DEG-1:0] din,
  output logic [DEG-1:0] sgn_ext,
  output logic           par
);
  logic [DEG-1:0] sgn_q;

  always_ff @(posedge clk) begin
    if (rst) sgn_q <= '0;
    else if (cap) sgn_q <= din;
  end

  assign par = ^sgn_q;

  for (genvar i = 0; i < DEG; i++) begin : g_ext
    assign sgn_ext[i] = par ^ sgn_q[i];
  end
endmodule

// File: rtl/ckn_ser.sv
module ckn_ser #(
  parameter int MSG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic             shift,
  input  logic [MSG_W-1:0] word,
  output logic             bit_o
);
  logic [MSG_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else if (ld) sh_q <= word;
    else if (shift) sh_q <= {sh_q[MSG_W-2:0], 1'b0};
  end

  assign bit_o = sh_q[MSG_W-1];
endmodule

// File: rtl/minsum_chk_node.sv
module minsum_chk_node #(
  parameter int DEG   = 4,
  parameter int MSG_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           sof,
  input  logic [DEG-1:0] din,
  output logic [DEG-1:0] dout,
  output logic           par_out
);
  import ckn_pkg::*;

  localparam int MAG_W = MSG_W - 1;
  localparam int CNT_W = $clog2(MSG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MSG_W - 1);
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic [CNT_W-1:0] ctr_q;
  logic             start, mstep, ld, uniq;
  logic [DEG-1:0]   cand_nx, sgn_ext;
  logic [MAG_W-1:0] min_now, min_inc;
  logic             par;
  logic             par_q;

  assign start = en & sof;
  assign mstep = en & ~sof & (ctr_q != '0);
  assign ld    = mstep & (ctr_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) ctr_q <= '0;
    else if (start) ctr_q <= CNT_W'(1);
    else if (mstep) ctr_q <= (ctr_q == LAST) ? '0 : ctr_q + CNT_W'(1);
  end

  ckn_min_track #(.DEG(DEG), .MAG_W(MAG_W)) u_min (
    .clk(clk), .rst(rst), .start(start), .step(mstep),
    .bits(din), .cand_nx(cand_nx), .min_now(min_now)
  );

  ckn_sign_par #(.DEG(DEG)) u_sgn (
    .clk(clk), .rst(rst), .cap(start), .din(din),
    .sgn_ext(sgn_ext), .par(par)
  );

  assign uniq    = is_single(32'(cand_nx));
  assign min_inc = (min_now == MAG_MAX) ? MAG_MAX : min_now + MAG_W'(1);

  for (genvar i = 0; i < DEG; i++) begin : g_edge
    logic [MAG_W-1:0] mag_i;
    assign mag_i = (uniq && cand_nx[i]) ? min_inc : min_now;
    ckn_ser #(.MSG_W(MSG_W)) u_ser (
      .clk(clk), .rst(rst), .ld(ld), .shift(en & ~ld),
      .word({sgn_ext[i], mag_i}), .bit_o(dout[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) par_q <= 1'b0;
    else if (ld) par_q <= par;
  end

  assign par_out = par_q;
endmodule

// File: rtl/minsum_chk_node_chk.sv
module minsum_chk_node_chk #(
  parameter int DEG = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic [DEG-1:0] dout,
  input logic           par_out,
  input logic           ld,
  input logic [DEG-1:0] cand_nx
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      // R1
      reset_clear_chk: assert (dout == '0 && par_out == 1'b0);
    end
  end

  // R7
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(dout) && $stable(par_out)));

  // R4
  par_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !ld) |=> $stable(par_out));

  // R3
  sign_par_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> ((^dout) == ((DEG % 2 == 0) ? par_out : 1'b0)));

  // R6
  cand_live_chk: assert property (@(posedge clk) disable iff (rst)
    ld |-> (cand_nx != '0));
endmodule

bind minsum_chk_node minsum_chk_node_chk #(.DEG(DEG)) u_chk (
  .clk(clk), .rst(rst), .en(en), .dout(dout), .par_out(par_out),
  .ld(ld), .cand_nx(cand_nx)
);

// File: tb/minsum_chk_node_tb.sv
module minsum_chk_node_tb;
  localparam int DEG   = 4;
  localparam int MSG_W = 4;
  localparam int MAG_W = MSG_W - 1;

  typedef logic [DEG-1:0][MAG_W-1:0] mags_t;
  typedef logic [DEG-1:0][MSG_W-1:0] words_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic sof = 1'b0;
  logic [DEG-1:0] din = '0;
  logic [DEG-1:0] dout;
  logic par_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  minsum_chk_node #(.DEG(DEG), .MSG_W(MSG_W)) u_dut (
    .clk(clk), .rst(rst), .en(en), .sof(sof), .din(din),
    .dout(dout), .par_out(par_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [DEG-1:0] d, input logic e,
                      output logic [DEG-1:0] q, output logic p);
    @(negedge clk);
    q = dout; p = par_out;
    sof = s; din = d; en = e;
    @(posedge clk);
  endtask

  // idle=1 sends no frame (sof low, din zero); stall_c inserts 3 frozen cycles
  task automatic slot(input bit idle, input mags_t m, input logic [DEG-1:0] sg,
                      input int stall_c, output words_t got, output logic gp);
    logic [DEG-1:0] q, bits, sq;
    logic p, sp;
    for (int c = 0; c < MSG_W; c++) begin
      for (int i = 0; i < DEG; i++)
        bits[i] = idle ? 1'b0 : ((c == 0) ? sg[i] : m[i][MAG_W-c]);
      if (c == stall_c) begin
        logic [DEG-1:0] held [3];
        logic hp [3];
        for (int k = 0; k < 3; k++) begin
          step(1'b1, ~bits, 1'b0, sq, sp);
          held[k] = sq; hp[k] = sp;
        end
        step(!idle && c == 0, bits, 1'b1, q, p);
        for (int k = 0; k < 3; k++)
          chk(held[k] == q && hp[k] == p, "R7 hold while disabled",
              int'(held[k]), int'(q));
      end else begin
        step(!idle && c == 0, bits, 1'b1, q, p);
      end
      if (c == 0) gp = p;
      else chk(p == gp, "R4 parity steady in slot", int'(p), int'(gp));
      for (int i = 0; i < DEG; i++) got[i][MSG_W-1-c] = q[i];
    end
  endtask

  function automatic words_t expect_w(input mags_t m, input logic [DEG-1:0] sg);
    words_t w;
    int mn = 1 << MAG_W;
    int cnt = 0;
    for (int i = 0; i < DEG; i++) if (int'(m[i]) < mn) mn = int'(m[i]);
    for (int i = 0; i < DEG; i++) if (int'(m[i]) == mn) cnt++;
    for (int i = 0; i < DEG; i++) begin
      w[i][MSG_W-1] = (^sg) ^ sg[i];
      w[i][MAG_W-1:0] = MAG_W'((cnt == 1 && int'(m[i]) == mn) ? mn + 1 : mn);
    end
    return w;
  endfunction

  function automatic bit is_tie(input mags_t m);
    int mn = 1 << MAG_W;
    int cnt = 0;
    for (int i = 0; i < DEG; i++) if (int'(m[i]) < mn) mn = int'(m[i]);
    for (int i = 0; i < DEG; i++) if (int'(m[i]) == mn) cnt++;
    return cnt > 1;
  endfunction

  task automatic compare(input words_t got, input logic gp, input mags_t m,
                         input logic [DEG-1:0] sg);
    words_t e = expect_w(m, sg);
    for (int i = 0; i < DEG; i++) begin
      chk(got[i][MSG_W-1] == e[i][MSG_W-1], "R3 extrinsic sign",
          int'(got[i][MSG_W-1]), int'(e[i][MSG_W-1]));
      if (is_tie(m))
        chk(got[i][MAG_W-1:0] == e[i][MAG_W-1:0], "R5 tied minimum",
            int'(got[i][MAG_W-1:0]), int'(e[i][MAG_W-1:0]));
      else
        chk(got[i][MAG_W-1:0] == e[i][MAG_W-1:0], "R6 unique minimum",
            int'(got[i][MAG_W-1:0]), int'(e[i][MAG_W-1:0]));
    end
    chk(gp == ^sg, "R4 parity flag", int'(gp), int'(^sg));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    words_t got;
    logic gp;
    logic [DEG-1:0] q;
    logic p;
    mags_t pm, m, jm;
    logic [DEG-1:0] psg, sg;
    bit pv = 0;

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: nothing loaded yet
    step(1'b0, '0, 1'b1, q, p);
    chk(q == '0 && p == 1'b0, "R1 reset state", int'({q, p}), 0);
    slot(1'b1, '0, '0, -1, got, gp);
    chk(got == '0 && gp == 1'b0, "R1 idle after reset", int'(got), 0);

    // R2/R3/R5/R6: every magnitude combination, back to back frames
    for (int n = 0; n < (1 << (MAG_W * DEG)); n++) begin
      m  = mags_t'(n);
      sg = DEG'((n * 7) ^ (n >> 5));
      slot(1'b0, m, sg, (n % 97 == 5) ? (1 + n % (MSG_W - 1)) : -1, got, gp);
      if (pv) compare(got, gp, pm, psg); // R2 slot alignment
      pm = m; psg = sg; pv = 1;
    end
    slot(1'b1, '0, '0, -1, got, gp);
    compare(got, gp, pm, psg);

    // R8: drained outputs read zero
    slot(1'b1, '0, '0, -1, got, gp);
    chk(got == '0, "R8 drained output zero", int'(got), 0);

    // R9: abandoned frame, then restart
    jm = '0;
    step(1'b1, '1, 1'b1, q, p);
    step(1'b0, '0, 1'b1, q, p);
    m = mags_t'(12'h5a3); sg = 4'b1011;
    slot(1'b0, m, sg, 0, got, gp);
    chk(got == '0, "R9 abandoned frame silent", int'(got), 0);
    slot(1'b1, jm, '0, -1, got, gp);
    compare(got, gp, m, sg);
    chk(got == expect_w(m, sg), "R9 restart frame", int'(got), int'(expect_w(m, sg)));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule